// File: doc/BRIEF.md
# Circular Capture Buffer with Trigger Positioning

The block records a parallel word of channel samples into a small on-chip ring memory, one word per sample strobe, with one bit per channel in each word. After an arm pulse it writes continuously and overwrites the oldest word once the ring has wrapped. A trigger pulse marks the event of interest. A programmable pre-trigger length sets where that event falls in the record. An optional delay moves the start of the post-trigger window a set number of clock cycles past the event. Once the post-trigger words are stored, writing stops and the record stays frozen until the next arm pulse.

The strobe source has two settings. In timing mode every clock cycle is a sample. In state mode a sample is taken only when an external qualifier shows the chosen edge, rising or falling. After capture, a read request streams the record out oldest-first over a valid/ready port. The trigger entry and the final entry are flagged. The data word is held while the consumer stalls (`out_ready` low), and the stream advances only on cycles where both `out_valid` and `out_ready` are high.

Top module: `trace_capture`

## Requirements
- R1: After reset `done`, `out_valid`, `trig_addr` and `pre_valid` are all 0.
- R2: The stored record begins with the last `pre_valid` samples strobed before the post-trigger window starts, in the order they arrived. Older samples have been overwritten first-in first-out.
- R3: Exactly DEPTH − `pre_len` samples are stored in the post-trigger window, counting the first sample of that window. `done` rises on the clock edge that writes the last one. Samples strobed while `done` is high are not stored.
- R4: `pre_len` may be anything from 0 (everything after the trigger) to DEPTH−1 (everything before it except the trigger entry). `trig_addr` equals the number of samples written since arm, modulo DEPTH, at the start of the post window. That entry is the first post sample.
- R5: With `trig_delay` = D, a trigger accepted at clock edge t starts the post window at edge t+D. Samples strobed before that edge remain pre-trigger history. D = 0 makes the sample at the trigger edge the first post sample.
- R6: With `state_mode` = 0 every clock is a sample. With `state_mode` = 1 a sample is taken only on edges where `qual_in` has risen since the last clock edge (`qual_fall` = 0) or has fallen since the last clock edge (`qual_fall` = 1).
- R7: A trigger that arrives before `pre_len` samples have been collected is accepted anyway. `pre_valid` then reports the number of pre-trigger samples actually held, which is min(samples collected, `pre_len`).
- R8: Only the first trigger after arm takes effect. A trigger during the delay or post window, before arm, or while done has no effect on the record or on `trig_addr`.
- R9: A `rd_go` pulse while `done` is high streams `pre_valid` + DEPTH − `pre_len` words. `out_is_trig` is high on word number `pre_valid` (counting from 0), and `out_last` is high on the final word. The word and `out_valid` hold while `out_ready` is low. `rd_go` is ignored while `done` is low.
- R10: An arm pulse at any time abandons the current capture or readout and starts a new capture with the configuration present on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture; latches `pre_len` and `trig_delay` |
| state_mode | input | 1 | 0: sample every clock, 1: sample on qualifier edge |
| qual_in | input | 1 | External sample qualifier |
| qual_fall | input | 1 | Qualifier edge select: 0 rising, 1 falling |
| samp_data | input | W | Channel sample word |
| trig_in | input | 1 | Trigger event pulse |
| pre_len | input | AW | Requested pre-trigger length, 0 to DEPTH−1 |
| trig_delay | input | DLY_W | Clock cycles from trigger to start of post window |
| done | output | 1 | Record complete and frozen |
| trig_addr | output | AW | Memory slot of the trigger entry |
| pre_valid | output | AW | Number of valid pre-trigger entries |
| rd_go | input | 1 | Start readout of a completed record |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Consumer accepts readout word |
| out_data | output | W | Readout word |
| out_is_trig | output | 1 | Current word is the trigger entry |
| out_last | output | 1 | Current word is the last of the record |

## Verification
The hardest case is a trigger that lands while the history is still short. Close behind it is a trigger that lands in state mode, where the sample count depends on qualifier edges rather than cycles, combined with a delay and a stray second trigger during the delay. The stimulus reaches these cases with directed runs and with randomised runs. The directed runs trigger at the very first sample, or after only three samples with a long pre-length. The randomised runs draw the mode, qualifier pattern, pre-length, delay and trigger cycle, and replay the result against a bench-side list of strobed samples. Readout always runs under random back-pressure, so both the hold behaviour and the wrap of the read pointer across slot 0 are exercised.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DELAY,
    PH_POST,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/cap_strobe.sv
module cap_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic state_mode,
  input  logic qual_in,
  input  logic qual_fall,
  output logic strobe
);
  logic qual_prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) qual_prev <= 1'b0;
    else        qual_prev <= qual_in;
  end

  assign rise   = qual_in & ~qual_prev;
  assign fall   = ~qual_in & qual_prev;
  assign strobe = active & (state_mode ? (qual_fall ? fall : rise) : 1'b1);

  // R6: in state mode a sample needs a qualifier change since the last edge
  a_r6_state_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state_mode && strobe) |-> (qual_in != $past(qual_in)));
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             trig_in,
  input  logic [AW-1:0]    pre_len,
  input  logic [DLY_W-1:0] trig_delay,
  input  logic             strobe,
  output logic             active,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             done,
  output logic [AW-1:0]    trig_addr,
  output logic [AW-1:0]    pre_valid,
  output logic [AW:0]      post_len
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE_L   = (AW+1)'(1);

  phase_t           phase;
  logic [AW-1:0]    wr_ptr, cfg_pre, trig_addr_q, pre_valid_q;
  logic [AW:0]      pre_cnt, post_left, left_eff;
  logic [DLY_W-1:0] cfg_dly, dly_cnt;
  logic             post_start, in_post;

  assign post_len   = DEPTH_L - {1'b0, cfg_pre};
  assign active     = (phase == PH_PRE) || (phase == PH_DELAY) || (phase == PH_POST);
  assign post_start = ~arm & (((phase == PH_PRE) && trig_in && (cfg_dly == '0)) ||
                              ((phase == PH_DELAY) && (dly_cnt == '0)));
  assign in_post    = (phase == PH_POST) || post_start;
  assign left_eff   = post_start ? post_len : post_left;
  assign wr_en      = strobe & ~arm;
  assign wr_addr    = wr_ptr;
  assign done       = (phase == PH_DONE);
  assign trig_addr  = trig_addr_q;
  assign pre_valid  = pre_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      wr_ptr      <= '0;
      pre_cnt     <= '0;
      post_left   <= '0;
      dly_cnt     <= '0;
      cfg_pre     <= '0;
      cfg_dly     <= '0;
      trig_addr_q <= '0;
      pre_valid_q <= '0;
    end else if (arm) begin
      phase       <= PH_PRE;
      wr_ptr      <= '0;
      pre_cnt     <= '0;
      post_left   <= '0;
      dly_cnt     <= '0;
      cfg_pre     <= pre_len;
      cfg_dly     <= trig_delay;
      trig_addr_q <= '0;
      pre_valid_q <= '0;
    end else begin
      if ((phase == PH_PRE) && trig_in && (cfg_dly != '0)) begin
        phase   <= PH_DELAY;
        dly_cnt <= cfg_dly - 1'b1;
      end
      if ((phase == PH_DELAY) && (dly_cnt != '0))
        dly_cnt <= dly_cnt - 1'b1;
      if (post_start) begin
        phase       <= PH_POST;
        trig_addr_q <= wr_ptr;
        pre_valid_q <= (pre_cnt < {1'b0, cfg_pre}) ? pre_cnt[AW-1:0] : cfg_pre;
        post_left   <= post_len;
      end
      if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (in_post) begin
          post_left <= left_eff - ONE_L;
          if (left_eff == ONE_L) phase <= PH_DONE;
        end else if (pre_cnt != DEPTH_L) begin
          pre_cnt <= pre_cnt + ONE_L;
        end
      end
    end
  end

  // R3: a frozen record takes no writes
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> !wr_en);
  // R8: once the post window is open the trigger slot cannot move
  a_r8_trig_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (((phase == PH_POST) || (phase == PH_DONE)) && !arm) |=> $stable(trig_addr));
  // R5: the delay window is not cut short
  a_r5_delay_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DELAY) && (dly_cnt != '0) && !arm) |=> (phase == PH_DELAY));
endmodule

// File: rtl/cap_reader.sv
module cap_reader #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          done,
  input  logic          rd_go,
  input  logic [AW-1:0] trig_addr,
  input  logic [AW-1:0] pre_valid,
  input  logic [AW:0]   post_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] rd_addr,
  output logic          out_is_trig,
  output logic          out_last
);
  localparam logic [AW:0] ONE_L = (AW+1)'(1);

  logic          busy;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   remaining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_ptr    <= '0;
      remaining <= '0;
    end else if (arm) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (rd_go && done) begin
        busy      <= 1'b1;
        rd_ptr    <= trig_addr - pre_valid;
        remaining <= {1'b0, pre_valid} + post_len;
      end
    end else if (out_ready) begin
      if (remaining == ONE_L) begin
        busy <= 1'b0;
      end else begin
        rd_ptr    <= rd_ptr + 1'b1;
        remaining <= remaining - ONE_L;
      end
    end
  end

  assign out_valid   = busy;
  assign rd_addr     = rd_ptr;
  assign out_is_trig = busy && (rd_ptr == trig_addr);
  assign out_last    = busy && (remaining == ONE_L);

  // R9: a stalled word stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready && !arm) |=> (busy && $stable(rd_ptr)));
  // R9: the stream only runs over a completed record
  a_r9_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> done);
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             state_mode,
  input  logic             qual_in,
  input  logic             qual_fall,
  input  logic [W-1:0]     samp_data,
  input  logic             trig_in,
  input  logic [AW-1:0]    pre_len,
  input  logic [DLY_W-1:0] trig_delay,
  output logic             done,
  output logic [AW-1:0]    trig_addr,
  output logic [AW-1:0]    pre_valid,
  input  logic             rd_go,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             out_is_trig,
  output logic             out_last
);
  logic          active, strobe, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   post_len;

  cap_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .active(active), .state_mode(state_mode),
    .qual_in(qual_in), .qual_fall(qual_fall), .strobe(strobe)
  );

  cap_ctrl #(.AW(AW), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_in(trig_in), .pre_len(pre_len),
    .trig_delay(trig_delay), .strobe(strobe), .active(active), .wr_en(wr_en),
    .wr_addr(wr_addr), .done(done), .trig_addr(trig_addr), .pre_valid(pre_valid),
    .post_len(post_len)
  );

  cap_mem #(.W(W), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(samp_data),
    .rd_addr(rd_addr), .rd_data(out_data)
  );

  cap_reader #(.AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_n), .arm(arm), .done(done), .rd_go(rd_go),
    .trig_addr(trig_addr), .pre_valid(pre_valid), .post_len(post_len),
    .out_ready(out_ready), .out_valid(out_valid), .rd_addr(rd_addr),
    .out_is_trig(out_is_trig), .out_last(out_last)
  );
endmodule

// File: tb/trace_capture_bench.sv
module trace_capture_bench;
  localparam int W = 8, AW = 4, DEPTH = 16, DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n, arm, state_mode, qual_in, qual_fall, trig_in, rd_go, out_ready;
  logic [W-1:0] samp_data;
  logic [AW-1:0] pre_len;
  logic [DLY_W-1:0] trig_delay;
  logic done, out_valid, out_is_trig, out_last;
  logic [AW-1:0] trig_addr, pre_valid;
  logic [W-1:0] out_data;

  trace_capture #(.W(W), .AW(AW), .DLY_W(DLY_W)) u_trace_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .state_mode(state_mode), .qual_in(qual_in),
    .qual_fall(qual_fall), .samp_data(samp_data), .trig_in(trig_in), .pre_len(pre_len),
    .trig_delay(trig_delay), .done(done), .trig_addr(trig_addr), .pre_valid(pre_valid),
    .rd_go(rd_go), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_trig(out_is_trig), .out_last(out_last)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] pre_q[$], post_q[$], exp_rec[$];

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic read_record(input string tag, input int exp_pv);
    int idx = 0;
    int guard = 0;
    bit stalled = 0;
    logic [W-1:0] held = '0;
    @(negedge clk); rd_go = 1'b1;
    @(negedge clk); rd_go = 1'b0;
    while (idx < exp_rec.size() && guard < 400) begin
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (stalled) check($sformatf("R9 hold %s", tag), int'(out_data), int'(held));
      stalled = 0;
      if (out_valid && out_ready) begin
        check($sformatf("R2 %s word %0d", tag, idx), int'(out_data), int'(exp_rec[idx]));
        check($sformatf("R4 %s trig flag %0d", tag, idx), int'(out_is_trig), int'(idx == exp_pv));
        check($sformatf("R9 %s last flag %0d", tag, idx), int'(out_last), int'(idx == exp_rec.size() - 1));
        idx++;
      end else if (out_valid) begin
        stalled = 1;
        held = out_data;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    check($sformatf("R9 %s words read", tag), idx, exp_rec.size());
    #1;
    check($sformatf("R9 %s stream ends", tag), int'(out_valid), 0);
  endtask

  task automatic run_capture(input string tag, input bit smode, input bit sfall,
                             input int pre, input int dly, input int trig_at, input int extra_at);
    bit q_prev = 0;
    bit bdone = 0;
    int npost = 0;
    int tail = 0;
    int plen = DEPTH - pre;
    int start = trig_at + dly;
    int exp_pv;
    pre_q.delete(); post_q.delete(); exp_rec.delete();
    @(negedge clk);
    state_mode = smode; qual_fall = sfall; pre_len = AW'(pre); trig_delay = DLY_W'(dly);
    qual_in = 1'b0; trig_in = 1'b0; rd_go = 1'b0; arm = 1'b1;
    for (int c = 0; c < 700 && tail < 4; c++) begin
      bit q, stb;
      @(negedge clk);
      arm = 1'b0;
      if (c == 1) check($sformatf("R9 %s rd_go ignored before done", tag), int'(out_valid), 0);
      rd_go = (c == 0);
      samp_data = W'($urandom);
      q = smode ? 1'($urandom_range(0, 1)) : 1'b0;
      qual_in = q;
      trig_in = (c == trig_at) || (c == extra_at);
      stb = smode ? (sfall ? (q_prev & ~q) : (q & ~q_prev)) : 1'b1;
      q_prev = q;
      if (bdone) tail++;
      else if (stb) begin
        if (c < start) pre_q.push_back(samp_data);
        else begin
          if (npost == plen - 1) check($sformatf("R3 %s done early", tag), int'(done), 0);
          post_q.push_back(samp_data);
          npost++;
          if (npost == plen) bdone = 1;
        end
      end
    end
    @(negedge clk);
    trig_in = 1'b0; rd_go = 1'b0;
    check($sformatf("R3 %s model finished", tag), int'(bdone), 1);
    check($sformatf("R3 %s done", tag), int'(done), 1);
    exp_pv = min_int(pre_q.size(), pre);
    check($sformatf("R7 %s pre_valid", tag), int'(pre_valid), exp_pv);
    check($sformatf("R4 %s trig_addr", tag), int'(trig_addr), pre_q.size() % DEPTH);
    for (int k = pre_q.size() - exp_pv; k < pre_q.size(); k++) exp_rec.push_back(pre_q[k]);
    foreach (post_q[k]) exp_rec.push_back(post_q[k]);
    read_record(tag, exp_pv);
  endtask

  initial begin
    #600000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a_5e07));
    rst_n = 1'b0; arm = 1'b0; state_mode = 1'b0; qual_in = 1'b0; qual_fall = 1'b0;
    trig_in = 1'b0; rd_go = 1'b0; out_ready = 1'b0; samp_data = '0; pre_len = '0; trig_delay = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 done after reset", int'(done), 0);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 trig_addr after reset", int'(trig_addr), 0);
    check("R1 pre_valid after reset", int'(pre_valid), 0);
    @(negedge clk); trig_in = 1'b1; rd_go = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0; rd_go = 1'b0;
    #1;
    check("R8 trigger while idle", int'(done), 0);
    check("R9 rd_go while idle", int'(out_valid), 0);

    run_capture("R2 timing mid", 0, 0, 8, 0, 20, -1);
    run_capture("R4 all post", 0, 0, 0, 0, 5, -1);
    run_capture("R4 max pre", 0, 0, 15, 0, 30, -1);
    run_capture("R7 early trigger", 0, 0, 12, 0, 3, -1);
    run_capture("R7 trigger first cycle", 0, 0, 10, 0, 0, -1);
    run_capture("R5 delay", 0, 0, 6, 9, 10, -1);
    run_capture("R8 second trigger", 0, 0, 5, 3, 12, 14);
    run_capture("R6 state rising", 1, 0, 7, 0, 40, -1);
    run_capture("R6 state falling", 1, 1, 4, 2, 35, 50);

    // R10: abandon a capture part way, then re-arm with new settings
    @(negedge clk);
    state_mode = 1'b0; pre_len = 4'd3; trig_delay = '0; arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    repeat (2) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    #1;
    check("R10 capture still open", int'(done), 0);
    run_capture("R10 rearm", 0, 0, 9, 0, 18, -1);

    for (int i = 0; i < 24; i++) begin
      bit sm = 1'($urandom_range(0, 1));
      int ta = int'($urandom_range(0, 25));
      int ex = ($urandom_range(0, 1) != 0) ? ta + 1 + int'($urandom_range(0, 10)) : -1;
      run_capture($sformatf("R6 random %0d", i), sm, 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, DEPTH - 1)), int'($urandom_range(0, 7)), ta, ex);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule